// File: doc/BRIEF.md
# Scrolling Character Window Display

This block shows stored text messages through a window five characters wide. Each message sits in an internal read-only character store. The store holds only the uppercase letters, the decimal digits and a blank code. A one-cycle scroll strobe slides the window one character to the right. Once the window has reached the final full view of a message, the next strobe either returns it to the start of the same message or moves on to the next message.

In rotate mode the stored messages come up one after another and wrap back to the first. In select mode an input picks one message, which then scrolls over and over. A message of five characters or fewer is shown left-aligned with blanks after it and never moves. The five window codes come out on one flat bus and are decoded by a glyph renderer further downstream.

Top module: `scroll_window_display`

## Requirements
- R1: After synchronous reset the window shows message 0 from character 0. The default message 0 is "SCROLL1", so the window reads "SCROL".
- R2: Window position i (0 = leftmost) sits on `win_codes[6*i+5 : 6*i]`. The codes are: letters A..Z are 0..25, digits 0..9 are 26..35, and blank is 63. No other value appears.
- R3: The window moves right by exactly one character for each clock cycle in which `tick` is high. In cycles with `tick` low and no message change, the window holds.
- R4: The window offset runs from 0 to (length - 5). In select mode, a tick on that last full window returns the offset to 0. For the seven-character message the views are 0-4, 1-5, 2-6 and then 0-4 again.
- R5: When `auto_rot` is 1, a tick on the last full window of a message loads the next message at offset 0. After the last message comes message 0.
- R6: A message of five characters or fewer shows blanks (63) in the positions past its end, and a tick leaves its offset at 0.
- R7: When `auto_rot` is 0 and `sel` names a stored message other than the one shown, the window shows that message from offset 0 in the next cycle. No tick is needed.
- R8: When `auto_rot` is 0, a `sel` value of 3 or above (no such message) is ignored and the current message stays.
- R9: When `auto_rot` is 1, `sel` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle scroll strobe |
| auto_rot | input | 1 | 1: rotate through messages; 0: show the message named by sel |
| sel | input | 2 | Message index used in select mode |
| win_codes | output | 30 | Five 6-bit character codes; position 0 in the low bits |

## Verification
The assertions assume that `tick` is a clean synchronous level that lasts a whole cycle. They also assume that `sel` and `auto_rot` only change between clock edges. The bench drives every input on the falling edge and holds it through the following rising edge. The properties that relate one cycle to the next are disabled while reset is high. The stimulus covers both modes, a `sel` value with no message behind it, and ticks that land exactly on the last full window, so the wrap and message-change paths are exercised.

// File: rtl/scrl_pkg.sv
package scrl_pkg;

    localparam int CHAR_W    = 6;
    localparam int WIN_LEN   = 5;
    localparam int MSG_COUNT = 3;
    localparam int MSG_MAX   = 8;

    typedef logic [CHAR_W-1:0]    char_t;
    typedef logic [8*MSG_MAX-1:0] text_t;

    localparam char_t BLANK = char_t'(63);

    // map an ASCII byte onto the 6-bit display code
    function automatic char_t enc(input logic [7:0] a);
        if (a >= 8'd65 && a <= 8'd90)
            return char_t'(a - 8'd65);
        else if (a >= 8'd48 && a <= 8'd57)
            return char_t'(a - 8'd48 + 8'd26);
        else
            return BLANK;
    endfunction

    // stored message text, right-justified in the vector
    function automatic text_t msg_text(input int m);
        case (m)
            0:       return text_t'("SCROLL1");
            1:       return text_t'("HI");
            2:       return text_t'("DATA2024");
            default: return '0;
        endcase
    endfunction

    function automatic int msg_len(input int m);
        case (m)
            0:       return 7;
            1:       return 2;
            2:       return 8;
            default: return 0;
        endcase
    endfunction

    // offset of the final full window (0 for short messages)
    function automatic int last_off(input int m);
        int n;
        n = msg_len(m);
        return (n > WIN_LEN) ? n - WIN_LEN : 0;
    endfunction

    function automatic char_t char_at(input int m, input int i);
        text_t t;
        int    n;
        t = msg_text(m);
        n = msg_len(m);
        if (i < 0 || i >= n)
            return BLANK;
        return enc(t[(n-1-i)*8 +: 8]);
    endfunction

endpackage

// File: rtl/scrl_ptr.sv
module scrl_ptr
    import scrl_pkg::*;
#(
    parameter int NUM_MSG = MSG_COUNT,
    parameter int MSG_W   = 2,
    parameter int OFF_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             auto_rot,
    input  logic [MSG_W-1:0] sel,
    output logic [MSG_W-1:0] msg_q,
    output logic [OFF_W-1:0] off_q
);

    localparam int LAST_MSG = NUM_MSG - 1;

    int   last;
    logic sel_ok;
    logic at_end;

    always_comb begin
        last   = last_off(int'(msg_q));
        sel_ok = int'(sel) < NUM_MSG;
        at_end = int'(off_q) >= last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
            off_q <= '0;
        end else if (!auto_rot && sel_ok && sel != msg_q) begin
            msg_q <= sel;
            off_q <= '0;
        end else if (tick) begin
            if (at_end) begin
                off_q <= '0;
                if (auto_rot)
                    msg_q <= (int'(msg_q) == LAST_MSG) ? '0 : msg_q + 1'b1;
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    // R3: no strobe in rotate mode -> nothing moves
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (auto_rot && !tick) |=> ($stable(off_q) && $stable(msg_q)));

    // R3: strobe before the end advances by one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (auto_rot && tick && int'(off_q) < last) |=> (off_q == $past(off_q) + 1'b1));

    // R4: offset never passes the final full window
    p_bound_r4: assert property (@(posedge clk) disable iff (rst)
        int'(off_q) <= last);

    // R5: strobe on final window moves to next message
    p_next_msg_r5: assert property (@(posedge clk) disable iff (rst)
        (auto_rot && tick && int'(off_q) == last) |=>
        (off_q == '0 && int'(msg_q) == ((int'($past(msg_q)) == LAST_MSG) ? 0 : int'($past(msg_q)) + 1)));

    // R6: short messages never leave offset 0
    p_short_still_r6: assert property (@(posedge clk) disable iff (rst)
        (msg_len(int'(msg_q)) <= WIN_LEN) |-> (off_q == '0));

    // R7: valid select in select mode is taken next cycle
    p_sel_load_r7: assert property (@(posedge clk) disable iff (rst)
        (!auto_rot && sel_ok && sel != msg_q) |=> (msg_q == $past(sel) && off_q == '0));

    // R8: select naming no message is ignored
    p_sel_invalid_r8: assert property (@(posedge clk) disable iff (rst)
        (!auto_rot && !sel_ok) |=> $stable(msg_q));

endmodule

// File: rtl/scrl_window.sv
module scrl_window
    import scrl_pkg::*;
#(
    parameter int WIN   = WIN_LEN,
    parameter int CW    = CHAR_W,
    parameter int MSG_W = 2,
    parameter int OFF_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MSG_W-1:0]  msg,
    input  logic [OFF_W-1:0]  off,
    output logic [WIN*CW-1:0] codes
);

    for (genvar i = 0; i < WIN; i++) begin : g_pos
        always_comb begin
            codes[i*CW +: CW] = CW'(char_at(int'(msg), int'(off) + i));
        end

        // R2: every position carries a letter, digit or blank code
        p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
            (int'(codes[i*CW +: CW]) < 36 || codes[i*CW +: CW] == CW'(63)));

        // R6: positions past the end of a message are blank
        p_pad_blank_r6: assert property (@(posedge clk) disable iff (rst)
            (int'(off) + i >= msg_len(int'(msg))) |-> (codes[i*CW +: CW] == CW'(63)));
    end

endmodule

// File: rtl/scroll_window_display.sv
module scroll_window_display
    import scrl_pkg::*;
#(
    parameter int NUM_MSG = MSG_COUNT,
    parameter int WIN     = WIN_LEN,
    parameter int CW      = CHAR_W,
    localparam int MSG_W  = (NUM_MSG > 1) ? $clog2(NUM_MSG) : 1,
    localparam int OFF_W  = (MSG_MAX > 1) ? $clog2(MSG_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              auto_rot,
    input  logic [MSG_W-1:0]  sel,
    output logic [WIN*CW-1:0] win_codes
);

    logic [MSG_W-1:0] msg_q;
    logic [OFF_W-1:0] off_q;

    scrl_ptr #(
        .NUM_MSG (NUM_MSG),
        .MSG_W   (MSG_W),
        .OFF_W   (OFF_W)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .auto_rot (auto_rot),
        .sel      (sel),
        .msg_q    (msg_q),
        .off_q    (off_q)
    );

    scrl_window #(
        .WIN   (WIN),
        .CW    (CW),
        .MSG_W (MSG_W),
        .OFF_W (OFF_W)
    ) u_win (
        .clk   (clk),
        .rst   (rst),
        .msg   (msg_q),
        .off   (off_q),
        .codes (win_codes)
    );

endmodule

// File: tb/scroll_window_display_tb.sv
module scroll_window_display_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        auto_rot = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [29:0] win_codes;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [29:0] exp;
        string       txt;
        string       tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    scroll_window_display u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .auto_rot  (auto_rot),
        .sel       (sel),
        .win_codes (win_codes)
    );

    // R2 encoding, written from the requirement
    function automatic logic [5:0] code(input byte c);
        if (c >= "A" && c <= "Z") return 6'(c - "A");
        if (c >= "0" && c <= "9") return 6'(c - "0" + 26);
        return 6'd63;
    endfunction

    function automatic logic [29:0] pack(input string w);
        logic [29:0] v;
        for (int i = 0; i < 5; i++)
            v[i*6 +: 6] = code(w[i]);
        return v;
    endfunction

    task automatic drive(input logic t, input logic a, input logic [1:0] s,
                         input string w, input string tag);
        item_t it;
        @(negedge clk);
        tick     = t;
        auto_rot = a;
        sel      = s;
        @(posedge clk);
        #1;
        it.exp = pack(w);
        it.txt = w;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares one expected item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (win_codes !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: window got %h expected %h (\"%s\")",
                             it.tag, win_codes, it.exp, it.txt);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset view, R2 codes
        drive(0, 0, 2'd0, "SCROL", "R1");
        drive(0, 0, 2'd0, "SCROL", "R3 hold");
        // R3 single steps, R4 wrap in select mode
        drive(1, 0, 2'd0, "CROLL", "R3");
        drive(0, 0, 2'd0, "CROLL", "R3 hold");
        drive(1, 0, 2'd0, "ROLL1", "R4");
        drive(1, 0, 2'd0, "SCROL", "R4 wrap");
        // R7 select change without tick, R6 padding
        drive(0, 0, 2'd1, "HI   ", "R7");
        drive(1, 0, 2'd1, "HI   ", "R6 no scroll");
        // R8 invalid select ignored
        drive(0, 0, 2'd3, "HI   ", "R8");
        drive(1, 0, 2'd3, "HI   ", "R8");
        // eight-character message
        drive(0, 0, 2'd2, "DATA2", "R7");
        drive(1, 0, 2'd2, "ATA20", "R3");
        drive(1, 0, 2'd2, "TA202", "R3");
        drive(1, 0, 2'd2, "A2024", "R4");
        drive(1, 0, 2'd2, "DATA2", "R4 wrap");
        // rotate mode: R9 sel ignored, R5 message order
        drive(0, 1, 2'd0, "DATA2", "R9");
        drive(1, 1, 2'd1, "ATA20", "R9");
        drive(1, 1, 2'd0, "TA202", "R3");
        drive(1, 1, 2'd0, "A2024", "R3");
        drive(1, 1, 2'd0, "SCROL", "R5 wrap to first");
        drive(1, 1, 2'd0, "CROLL", "R3");
        drive(1, 1, 2'd0, "ROLL1", "R3");
        drive(0, 1, 2'd0, "ROLL1", "R3 hold");
        drive(1, 1, 2'd0, "HI   ", "R5");
        drive(1, 1, 2'd0, "DATA2", "R5 short");
        // reset mid-run returns to R1 view
        @(negedge clk);
        tick = 1'b0;
        rst  = 1'b1;
        @(negedge clk);
        rst  = 1'b0;
        drive(0, 1, 2'd0, "SCROL", "R1");
        @(negedge clk);
        tick = 1'b0;
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule